// File: doc/BRIEF.md
# SECDED Memory Word Protector

This block guards a memory word against soft errors with a single-error-correct, double-error-detect code. On the write side it takes a data word and produces the check field: Hamming check bits plus one overall even-parity bit. The caller stores this field next to the data. On the read side it takes the stored data and check field and recomputes the Hamming bits from the data. XOR with the stored bits gives a syndrome, and the block then tests parity over the whole stored word.

A decision table combines the syndrome and the parity result. A clean word passes through unchanged. A single flipped bit is inverted at the codeword position the syndrome names. A flipped parity bit alone is reported as corrected and leaves the data untouched. Two flipped bits are flagged as uncorrectable. The encoder is combinational. The read result is registered once, so corrected data, flags and syndrome appear one clock after the read inputs.

One parameter sets the data width. With 4 data bits there are 3 Hamming bits plus parity. With 64 data bits there are 7 Hamming bits plus parity, so 72 bits are stored.

Top module: `secded_guard`

## Requirements
- R1: Codeword positions are numbered from 1. Hamming bit j (j counted from 0) sits at position 2^j. Data bit i (bit 0 first) takes the i-th position that is not a power of two, in rising order. Hamming bit j is the XOR of the data bits whose position has bit j set. For 4 data bits this gives position order C1, C2, b1, C3, b2, b3, b4. Here C1 = b1^b2^b4, C2 = b1^b3^b4 and C3 = b2^b3^b4, with b1 = data bit 0.
- R2: The check field holds the Hamming bits in its low bits, with bit j holding Hamming bit j. Its top bit is the overall parity, chosen so that the data and the full check field together hold an even number of ones. Data 4'b1011 encodes to check field 4'b0001.
- R3: The syndrome output is the stored Hamming bits XOR the Hamming bits recomputed from the read data. A single flipped Hamming bit j gives syndrome 2^j.
- R4: A zero syndrome with even overall parity yields the read data unchanged, with both flags low.
- R5: A nonzero syndrome no larger than the codeword length, with odd overall parity, raises single_err only. The data bit at the position named by the syndrome is inverted. A flipped Hamming bit leaves the data unchanged.
- R6: A zero syndrome with odd overall parity is a parity-bit-only error. single_err is raised and the data is passed through unchanged.
- R7: A nonzero syndrome with even overall parity raises double_err only, and the raw read data is passed through.
- R8: A syndrome larger than the codeword length with odd overall parity raises double_err only, with the raw data passed through.
- R9: Corrected data, flags and syndrome are registered and appear one clock after the read inputs. Synchronous active-high reset clears them all to zero.
- R10: With 64 data bits the check field is 8 bits wide (7 Hamming bits plus parity), the codeword is 71 bits long, and R1 to R8 hold at that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | DATA_W | Data word to be stored |
| wr_check | output | HAM_W+1 | Check field for wr_data (Hamming bits, parity on top) |
| rd_data | input | DATA_W | Data word read from storage |
| rd_check | input | HAM_W+1 | Check field read from storage |
| fix_data | output | DATA_W | Corrected read data, registered |
| single_err | output | 1 | Single error corrected (data or check bit), registered |
| double_err | output | 1 | Uncorrectable error detected, registered |
| syndrome | output | HAM_W | Raw syndrome, registered |

## Verification
On every cycle the assertions check several invariants. The two flags never rise together. A double error always carries a nonzero syndrome. The data passes through raw whenever no correction applies, and a correction changes at most one data bit. Only the bench's scenarios can show that the correction lands on the right bit, that the encoded field matches the position coverage rules, that flipping every stored bit and every pair of bits is classified correctly, and that an out-of-range syndrome in the wide configuration is treated as uncorrectable.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // Number of Hamming bits needed so that 2^k covers every codeword position.
    function automatic int ham_bits(input int dw);
        int k;
        k = 1;
        for (int s = 0; s < 32; s++) begin
            if ((1 << k) < dw + k + 1) k++;
        end
        return k;
    endfunction

    // Codeword position (1-based) of data bit idx: the idx-th non-power-of-two.
    function automatic int slot_of(input int idx);
        int seen;
        int found;
        seen  = 0;
        found = 0;
        for (int q = 3; q < 1024; q++) begin
            if (found == 0 && (q & (q - 1)) != 0) begin
                if (seen == idx) found = q;
                seen++;
            end
        end
        return found;
    endfunction

    typedef enum logic [1:0] {
        EK_NONE     = 2'd0,
        EK_SINGLE   = 2'd1,
        EK_PAR_ONLY = 2'd2,
        EK_DOUBLE   = 2'd3
    } err_kind_e;

    // Decision table combining syndrome state and overall parity.
    function automatic err_kind_e classify(input logic syn_zero,
                                           input logic par_odd,
                                           input logic syn_in_range);
        err_kind_e k;
        if (syn_zero && !par_odd)           k = EK_NONE;
        else if (syn_zero && par_odd)       k = EK_PAR_ONLY;
        else if (par_odd && syn_in_range)   k = EK_SINGLE;
        else                                k = EK_DOUBLE;
        return k;
    endfunction

endpackage

// File: rtl/secded_hgen.sv
module secded_hgen
    import secded_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] data,
    output logic [ham_bits(DATA_W)-1:0] ham
);
    localparam int HAM_W = ham_bits(DATA_W);

    logic [DATA_W-1:0] cover_terms [HAM_W];

    for (genvar gj = 0; gj < HAM_W; gj++) begin : g_chk
        for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
            localparam int  SLOT = slot_of(gi);
            localparam bit  HIT  = ((SLOT >> gj) & 1) == 1;
            if (HIT) begin : g_in
                assign cover_terms[gj][gi] = data[gi];
            end else begin : g_out
                assign cover_terms[gj][gi] = 1'b0;
            end
        end
        assign ham[gj] = ^cover_terms[gj];
    end

endmodule

// File: rtl/secded_encode.sv
module secded_encode
    import secded_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0]         data,
    output logic [ham_bits(DATA_W):0] check
);
    localparam int HAM_W = ham_bits(DATA_W);

    logic [HAM_W-1:0] ham;

    secded_hgen #(.DATA_W(DATA_W)) u_hgen (
        .data (data),
        .ham  (ham)
    );

    // Overall even parity across data and Hamming bits.
    assign check = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/secded_decode.sv
module secded_decode
    import secded_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0]           data_in,
    input  logic [ham_bits(DATA_W):0]   check_in,
    output logic [DATA_W-1:0]           data_out,
    output logic                        single_err,
    output logic                        double_err,
    output logic [ham_bits(DATA_W)-1:0] syn
);
    localparam int HAM_W  = ham_bits(DATA_W);
    localparam int CW_LEN = DATA_W + HAM_W;

    logic [HAM_W-1:0]  ham_now;
    logic              par_odd;
    logic              in_range;
    err_kind_e         kind;
    logic [DATA_W-1:0] flip;

    secded_hgen #(.DATA_W(DATA_W)) u_hgen (
        .data (data_in),
        .ham  (ham_now)
    );

    assign syn      = check_in[HAM_W-1:0] ^ ham_now;
    assign par_odd  = (^data_in) ^ (^check_in);
    assign in_range = (32'(syn) <= 32'(CW_LEN));
    assign kind     = classify(syn == '0, par_odd, in_range);

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_fix
        localparam int               SLOT   = slot_of(gi);
        localparam logic [HAM_W-1:0] SLOT_V = SLOT[HAM_W-1:0];
        assign flip[gi] = (kind == EK_SINGLE) && (syn == SLOT_V);
    end

    assign data_out   = data_in ^ flip;
    assign single_err = (kind == EK_SINGLE) || (kind == EK_PAR_ONLY);
    assign double_err = (kind == EK_DOUBLE);

endmodule

// File: rtl/secded_guard.sv
module secded_guard
    import secded_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [ham_bits(DATA_W):0]   wr_check,
    input  logic [DATA_W-1:0]           rd_data,
    input  logic [ham_bits(DATA_W):0]   rd_check,
    output logic [DATA_W-1:0]           fix_data,
    output logic                        single_err,
    output logic                        double_err,
    output logic [ham_bits(DATA_W)-1:0] syndrome
);
    localparam int HAM_W = ham_bits(DATA_W);

    logic [DATA_W-1:0] dec_data;
    logic              dec_single;
    logic              dec_double;
    logic [HAM_W-1:0]  dec_syn;

    secded_encode #(.DATA_W(DATA_W)) u_enc (
        .data  (wr_data),
        .check (wr_check)
    );

    secded_decode #(.DATA_W(DATA_W)) u_dec (
        .data_in    (rd_data),
        .check_in   (rd_check),
        .data_out   (dec_data),
        .single_err (dec_single),
        .double_err (dec_double),
        .syn        (dec_syn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fix_data   <= '0;
            single_err <= 1'b0;
            double_err <= 1'b0;
            syndrome   <= '0;
        end else begin
            fix_data   <= dec_data;
            single_err <= dec_single;
            double_err <= dec_double;
            syndrome   <= dec_syn;
        end
    end

    // Marks that the output registers hold a decoded word rather than reset values.
    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(single_err && double_err));

    p_double_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        double_err |-> syndrome != '0);

    p_clean_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (live_q && !single_err && !double_err) |-> (fix_data == $past(rd_data) && syndrome == '0));

    p_parity_only_r6: assert property (@(posedge clk) disable iff (rst)
        (live_q && single_err && syndrome == '0) |-> fix_data == $past(rd_data));

    p_one_bit_fix_r5: assert property (@(posedge clk) disable iff (rst)
        (live_q && single_err) |-> $countones(fix_data ^ $past(rd_data)) <= 1);

    p_double_raw_r8: assert property (@(posedge clk) disable iff (rst)
        (live_q && double_err) |-> fix_data == $past(rd_data));

endmodule

// File: tb/secded_guard_test.sv
module secded_guard_test;

    logic clk = 1'b0;
    always #5ns clk = ~clk;

    logic        rst;
    logic [3:0]  n_wr, n_rd, n_wchk, n_rchk, n_fix;
    logic        n_se, n_de;
    logic [2:0]  n_syn;
    logic [63:0] w_wr, w_rd, w_fix;
    logic [7:0]  w_wchk, w_rchk;
    logic        w_se, w_de;
    logic [6:0]  w_syn;

    secded_guard #(.DATA_W(4)) uut (
        .clk(clk), .rst(rst), .wr_data(n_wr), .wr_check(n_wchk),
        .rd_data(n_rd), .rd_check(n_rchk), .fix_data(n_fix),
        .single_err(n_se), .double_err(n_de), .syndrome(n_syn)
    );

    secded_guard #(.DATA_W(64)) uut_wide (
        .clk(clk), .rst(rst), .wr_data(w_wr), .wr_check(w_wchk),
        .rd_data(w_rd), .rd_check(w_rchk), .fix_data(w_fix),
        .single_err(w_se), .double_err(w_de), .syndrome(w_syn)
    );

    typedef struct {
        bit          wide;
        logic [63:0] data;
        bit          se;
        bit          de;
        logic [7:0]  syn;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   total = 0;
    int   bad   = 0;

    // k-th codeword position that is not a power of two (bit 0 -> 3).
    function automatic int bpos(input int idx);
        int p;
        int n;
        p = 2;
        n = -1;
        while (n < idx) begin
            p++;
            if ((p & (p - 1)) != 0) n++;
        end
        return p;
    endfunction

    // Check field from the position-XOR view: Hamming bits equal the XOR of
    // positions of set data bits; parity evens out the stored word.
    function automatic logic [7:0] ref_check(input logic [63:0] d, input int dw, input int k);
        logic [7:0] s;
        logic       par;
        s = 8'h00;
        par = 1'b0;
        for (int i = 0; i < dw; i++) begin
            if (d[i]) begin
                s   = s ^ 8'(bpos(i));
                par = ~par;
            end
        end
        for (int j = 0; j < k; j++) par = par ^ s[j];
        s = s & 8'((1 << k) - 1);
        s[k] = par;
        return s;
    endfunction

    // Syndrome produced by flipping stored bit b (data first, then Hamming, then parity).
    function automatic logic [7:0] bit_syn(input int b, input int dw, input int k);
        if (b < dw)          return 8'(bpos(b));
        else if (b < dw + k) return 8'(1 << (b - dw));
        else                 return 8'h00;
    endfunction

    task automatic put(input bit wide, input logic [71:0] word, input logic [63:0] edata,
                       input bit se, input bit de, input logic [7:0] syn, input string req);
        exp_t e;
        @(negedge clk);
        if (wide) begin
            w_rd   = word[63:0];
            w_rchk = word[71:64];
        end else begin
            n_rd   = word[3:0];
            n_rchk = word[7:4];
        end
        e.wide = wide; e.data = edata; e.se = se; e.de = de; e.syn = syn; e.req = req;
        sb.push_back(e);
    endtask

    task automatic chk_enc(input bit ok, input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s encode: got check=%h exp check=%h", req, got, exp);
        end
    endtask

    // Monitor: one expected item per decoded word, compared after the capturing edge.
    always @(posedge clk) begin
        #1ns;
        if (sb.size() != 0) begin
            exp_t e;
            bit ok;
            e = sb.pop_front();
            if (e.wide)
                ok = (w_fix === e.data) && (w_se === e.se) && (w_de === e.de) && (w_syn === e.syn[6:0]);
            else
                ok = (n_fix === e.data[3:0]) && (n_se === e.se) && (n_de === e.de) && (n_syn === e.syn[2:0]);
            total++;
            if (!ok) begin
                bad++;
                if (e.wide)
                    $display("FAIL %s: got data=%h se=%b de=%b syn=%h exp data=%h se=%b de=%b syn=%h",
                             e.req, w_fix, w_se, w_de, w_syn, e.data, e.se, e.de, e.syn[6:0]);
                else
                    $display("FAIL %s: got data=%h se=%b de=%b syn=%h exp data=%h se=%b de=%b syn=%h",
                             e.req, n_fix, n_se, n_de, n_syn, e.data[3:0], e.se, e.de, e.syn[2:0]);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got running exp finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  c;
        logic [71:0] word;
        logic [71:0] w;
        logic [63:0] d64;
        rst = 1'b1;
        n_wr = '0; n_rd = '0; n_rchk = '0;
        w_wr = '0; w_rd = 64'hFFFF_0000_1234_5678; w_rchk = 8'h5A;
        n_rd = 4'hF; n_rchk = 4'h3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset clears every registered output
        total++;
        if (n_fix !== 4'h0 || n_se !== 1'b0 || n_de !== 1'b0 || n_syn !== 3'h0 ||
            w_fix !== 64'h0 || w_se !== 1'b0 || w_de !== 1'b0 || w_syn !== 7'h0) begin
            bad++;
            $display("FAIL R9 reset: got n_fix=%h n_se=%b n_de=%b w_fix=%h w_se=%b w_de=%b exp all zero",
                     n_fix, n_se, n_de, w_fix, w_se, w_de);
        end
        rst = 1'b0;

        // R2: known encoding
        n_wr = 4'b1011;
        #1ns;
        chk_enc(n_wchk === 4'b0001, "R2", {4'h0, n_wchk}, 8'h01);

        // Narrow configuration: every data value, every single and double flip.
        for (int d = 0; d < 16; d++) begin
            c = ref_check(64'(d), 4, 3);
            n_wr = 4'(d);
            #1ns;
            chk_enc(n_wchk === c[3:0], "R1", {4'h0, n_wchk}, {4'h0, c[3:0]});
            word = 72'(d) | (72'(c[3:0]) << 4);
            put(1'b0, word, 64'(d), 1'b0, 1'b0, 8'h00, "R4");
            for (int b = 0; b < 8; b++) begin
                w = word ^ (72'(1) << b);
                if (b == 7)
                    put(1'b0, w, 64'(d), 1'b1, 1'b0, 8'h00, "R6");
                else if (b >= 4)
                    put(1'b0, w, 64'(d), 1'b1, 1'b0, bit_syn(b, 4, 3), "R3");
                else
                    put(1'b0, w, 64'(d), 1'b1, 1'b0, bit_syn(b, 4, 3), "R5");
            end
            for (int b1 = 0; b1 < 8; b1++) begin
                for (int b2 = b1 + 1; b2 < 8; b2++) begin
                    w = word ^ (72'(1) << b1) ^ (72'(1) << b2);
                    put(1'b0, w, 64'(w[3:0]), 1'b0, 1'b1,
                        bit_syn(b1, 4, 3) ^ bit_syn(b2, 4, 3), "R7");
                end
            end
        end

        // Wide configuration (R10), plus the out-of-range syndrome case (R8).
        for (int t = 0; t < 80; t++) begin
            int b1;
            int b2;
            d64 = {$urandom, $urandom};
            if (t == 0) d64 = 64'h0;
            if (t == 1) d64 = '1;
            c = ref_check(d64, 64, 7);
            w_wr = d64;
            #1ns;
            chk_enc(w_wchk === c, "R10", w_wchk, c);
            word = {c, d64};
            put(1'b1, word, d64, 1'b0, 1'b0, 8'h00, "R10");
            b1 = (t < 72) ? t : int'($urandom % 72);
            w = word ^ (72'(1) << b1);
            put(1'b1, w, d64, 1'b1, 1'b0, bit_syn(b1, 64, 7), "R10");
            b2 = (b1 + 1 + int'($urandom % 71)) % 72;
            w = word ^ (72'(1) << b1) ^ (72'(1) << b2);
            put(1'b1, w, w[63:0], 1'b0, 1'b1, bit_syn(b1, 64, 7) ^ bit_syn(b2, 64, 7), "R10");
            // R8: all seven Hamming bits flipped -> syndrome 127 > 71, odd parity
            w = word ^ (72'h7F << 64);
            put(1'b1, w, d64, 1'b0, 1'b1, 8'h7F, "R8");
        end

        repeat (4) @(posedge clk);
        #2ns;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule